// File: doc/BRIEF.md
# Bidirectional Tower-Field AES Byte Substitution Unit

This block performs the AES byte substitution in either direction on one byte per clock. A per-byte direction input selects between the forward substitution and its inverse. Both directions share a single GF(2^8) multiplicative inverter. The inverter does not use a stored 256-entry table. It maps the byte into a composite field built as a quadratic extension over GF(2^4), inverts it there with small 4-bit arithmetic, and maps the result back to the standard byte basis.

The byte, its direction and a valid strobe are captured in an input register stage on a rising edge. The substituted byte and a matching valid strobe are then available as soon as that edge has passed, one clock after the input was presented. A new byte may be accepted on every cycle. When no byte is accepted, the output keeps its previous value.

Top module: `sbox_tower`

## Requirements
- R1: With direction 0, the result is A(inv(x)), where inv is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1. A(y) is bit i equal to y[i]^y[i+4]^y[i+5]^y[i+6]^y[i+7] (indices mod 8) xor bit i of 8'h63.
- R2: With direction 1, the result is inv(B(x)), where B(y) is bit i equal to y[i+2]^y[i+5]^y[i+7] (indices mod 8) xor bit i of 8'h05.
- R3: The inverter maps 8'h00 to 8'h00. As a result, forward 8'h00 gives 8'h63, inverse 8'h63 gives 8'h00, and inverse 8'h00 gives 8'h52.
- R4: A byte applied with in_valid high is captured at a rising edge. After that edge, out_valid is 1 and out_byte holds its substitution. After an edge where in_valid is low, out_valid is 0.
- R5: An edge with in_valid low leaves out_byte unchanged, whatever in_byte and in_inv carry at that edge.
- R6: While reset is active and after it is released, before any byte has been captured, out_valid is 0 and out_byte is 8'h63 (the forward image of the reset value 8'h00).
- R7: The inverse direction undoes the forward direction for all 256 bytes.
- R8: The direction is taken per byte. Back-to-back bytes with alternating direction each get their own direction's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture the input byte on this edge |
| in_inv | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result corresponds to a byte captured on the last edge |
| out_byte | output | 8 | Substituted byte |

## Verification
The assertions assume that reset is applied from time zero. They also assume that in_valid, in_inv and in_byte are defined, non-X values at every rising edge after reset, because the hold and latency properties compare registered values across edges. The bench holds reset from the start and changes every input only at falling edges, so each input is settled and defined when it is sampled. The inverter properties check the composite-field result by multiplying it back with an independent composite multiply. This holds for any legal byte, so the stimulus needs no further restriction.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam logic [NIB_W-1:0]  GF16_POLY_LO = 4'h3;   // x^4 + x + 1, low terms
  localparam logic [NIB_W-1:0]  EXT_LAMBDA   = 4'he;   // x^2 + x + {e}
  localparam logic [BYTE_W-1:0] FWD_CONST    = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST    = 8'h05;

  function automatic logic [NIB_W-1:0] gf16_mul(logic [NIB_W-1:0] a, logic [NIB_W-1:0] b);
    logic [NIB_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[NIB_W-1] ? ((sh << 1) ^ GF16_POLY_LO) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [NIB_W-1:0] gf16_sq(logic [NIB_W-1:0] a);
    return gf16_mul(a, a);
  endfunction

  // a^14 = a^2 * a^4 * a^8 ; zero stays zero
  function automatic logic [NIB_W-1:0] gf16_inv(logic [NIB_W-1:0] a);
    logic [NIB_W-1:0] p2, p4, p8;
    p2 = gf16_sq(a);
    p4 = gf16_sq(p2);
    p8 = gf16_sq(p4);
    return gf16_mul(p2, gf16_mul(p4, p8));
  endfunction

  // composite byte {hi, lo} = hi*x + lo, reduced by x^2 = x + lambda
  function automatic logic [BYTE_W-1:0] gfc_mul(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b);
    logic [NIB_W-1:0] hh, hl, lh, ll;
    hh = gf16_mul(a[7:4], b[7:4]);
    hl = gf16_mul(a[7:4], b[3:0]);
    lh = gf16_mul(a[3:0], b[7:4]);
    ll = gf16_mul(a[3:0], b[3:0]);
    return {hh ^ hl ^ lh, gf16_mul(EXT_LAMBDA, hh) ^ ll};
  endfunction

  function automatic logic [BYTE_W-1:0] gfc_inv(logic [BYTE_W-1:0] a);
    logic [NIB_W-1:0] hi, lo, det, det_inv;
    hi      = a[7:4];
    lo      = a[3:0];
    det     = gf16_mul(EXT_LAMBDA, gf16_sq(hi)) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
    det_inv = gf16_inv(det);
    return {gf16_mul(hi, det_inv), gf16_mul(hi ^ lo, det_inv)};
  endfunction

  // XOR of the columns selected by the set bits of a
  function automatic logic [BYTE_W-1:0] map_cols(logic [8*BYTE_W-1:0] cols, logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] y;
    y = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (a[i]) y = y ^ cols[i*BYTE_W +: BYTE_W];
    return y;
  endfunction

  // first composite element that is a root of x^8+x^4+x^3+x+1
  function automatic logic [BYTE_W-1:0] find_root();
    logic [BYTE_W-1:0] r, p2, p3, p4, p8, val, found;
    logic hit;
    hit   = 1'b0;
    found = 8'h02;
    for (int c = 2; c < 256; c++) begin
      r   = BYTE_W'(c);
      p2  = gfc_mul(r, r);
      p3  = gfc_mul(p2, r);
      p4  = gfc_mul(p2, p2);
      p8  = gfc_mul(p4, p4);
      val = p8 ^ p4 ^ p3 ^ r ^ 8'h01;
      if (!hit && val == 8'h00) begin
        hit   = 1'b1;
        found = r;
      end
    end
    return found;
  endfunction

  // column i = root^i : image of the standard basis bit i
  function automatic logic [8*BYTE_W-1:0] build_to_comp();
    logic [8*BYTE_W-1:0] cols;
    logic [BYTE_W-1:0]   rt, pw;
    rt = find_root();
    pw = 8'h01;
    for (int i = 0; i < BYTE_W; i++) begin
      cols[i*BYTE_W +: BYTE_W] = pw;
      pw = gfc_mul(pw, rt);
    end
    return cols;
  endfunction

  // inverse map found by search over each composite basis vector
  function automatic logic [8*BYTE_W-1:0] build_to_std(logic [8*BYTE_W-1:0] fwd);
    logic [8*BYTE_W-1:0] cols;
    cols = '0;
    for (int j = 0; j < BYTE_W; j++)
      for (int v = 1; v < 256; v++)
        if (map_cols(fwd, BYTE_W'(v)) == (8'h01 << j))
          cols[j*BYTE_W +: BYTE_W] = BYTE_W'(v);
    return cols;
  endfunction

  localparam logic [8*BYTE_W-1:0] TO_COMP_COLS = build_to_comp();
  localparam logic [8*BYTE_W-1:0] TO_STD_COLS  = build_to_std(TO_COMP_COLS);

  function automatic logic [BYTE_W-1:0] to_comp(logic [BYTE_W-1:0] a);
    return map_cols(TO_COMP_COLS, a);
  endfunction

  function automatic logic [BYTE_W-1:0] to_std(logic [BYTE_W-1:0] a);
    return map_cols(TO_STD_COLS, a);
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(logic [BYTE_W-1:0] a, int n);
    logic [2*BYTE_W-1:0] t;
    t = {a, a} << n;
    return t[2*BYTE_W-1:BYTE_W];
  endfunction

endpackage

// File: rtl/sbox_tower_affine.sv
module sbox_tower_affine
  import sbox_tower_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] y
);

  generate
    if (INVERSE) begin : g_inv
      assign y = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ INV_CONST;
    end else begin : g_fwd
      assign y = a ^ rotl8(a, 1) ^ rotl8(a, 2) ^ rotl8(a, 3) ^ rotl8(a, 4) ^ FWD_CONST;
    end
  endgenerate

endmodule

// File: rtl/sbox_tower_inverter.sv
module sbox_tower_inverter
  import sbox_tower_pkg::*;
(
  input  logic [BYTE_W-1:0] std_in,
  output logic [BYTE_W-1:0] comp_in,
  output logic [BYTE_W-1:0] comp_out,
  output logic [BYTE_W-1:0] std_out
);

  assign comp_in  = to_comp(std_in);
  assign comp_out = gfc_inv(comp_in);
  assign std_out  = to_std(comp_out);

endmodule

// File: rtl/sbox_tower.sv
module sbox_tower
  import sbox_tower_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_inv,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);

  logic [BYTE_W-1:0] byte_q;
  logic              inv_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      inv_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        byte_q <= in_byte;
        inv_q  <= in_inv;
      end
    end
  end

  logic [BYTE_W-1:0] pre_aff;    // inverse affine of the captured byte
  logic [BYTE_W-1:0] inv_src;    // inverter operand
  logic [BYTE_W-1:0] inv_comp_in;
  logic [BYTE_W-1:0] inv_comp_out;
  logic [BYTE_W-1:0] inv_res;
  logic [BYTE_W-1:0] post_aff;   // forward affine of the inverse

  sbox_tower_affine #(.INVERSE(1'b1)) u_aff_in (
    .a (byte_q),
    .y (pre_aff)
  );

  assign inv_src = inv_q ? pre_aff : byte_q;

  sbox_tower_inverter u_inv (
    .std_in   (inv_src),
    .comp_in  (inv_comp_in),
    .comp_out (inv_comp_out),
    .std_out  (inv_res)
  );

  sbox_tower_affine #(.INVERSE(1'b0)) u_aff_out (
    .a (inv_res),
    .y (post_aff)
  );

  assign out_valid = vld_q;
  assign out_byte  = inv_q ? inv_res : post_aff;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                               // R4
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                             // R4
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_byte));                                      // R5
  AST_INV_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_comp_in != 8'h00) |-> (gfc_mul(inv_comp_in, inv_comp_out) == 8'h01)); // R1
  AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_src == 8'h00) |-> (inv_res == 8'h00));                            // R3
  AST_BASIS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    to_std(inv_comp_in) == inv_src);                                       // R2

endmodule

// File: tb/sbox_tower_tb_top.sv
module sbox_tower_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_inv = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_tower dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte)
  );

  // reference arithmetic: shift-and-add multiply, brute-force inverse
  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_inv(logic [7:0] a);
    logic [7:0] r = 8'h00;
    for (int c = 1; c < 256; c++)
      if (ref_mul(a, 8'(c)) == 8'h01) r = 8'(c);
    return r;
  endfunction

  function automatic logic [7:0] ref_fwd(logic [7:0] a);
    logic [7:0] s = ref_inv(a);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = s[i] ^ s[(i+4)%8] ^ s[(i+5)%8] ^ s[(i+6)%8] ^ s[(i+7)%8];
    return y ^ 8'h63;
  endfunction

  function automatic logic [7:0] ref_bwd(logic [7:0] a);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = a[(i+2)%8] ^ a[(i+5)%8] ^ a[(i+7)%8];
    return ref_inv(y ^ 8'h05);
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample one time unit after the capturing edge
  task automatic apply(input logic dir, input logic [7:0] b, output logic [7:0] got);
    @(negedge clk);
    in_valid = 1'b1;
    in_inv   = dir;
    in_byte  = b;
    @(posedge clk);
    #1;
    got = out_byte;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] got, held, fwd;
    repeat (2) @(posedge clk);
    #1;
    check("R6 reset valid", {8'h00, out_valid}, 9'h000);
    check("R6 reset byte", {1'b0, out_byte}, 9'h063);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R6 after release", {out_valid, out_byte}, {1'b0, 8'h63});

    // corner values
    apply(1'b0, 8'h00, got);
    check("R3 fwd 00", {out_valid, got}, {1'b1, 8'h63});
    apply(1'b1, 8'h63, got);
    check("R3 inv 63", {out_valid, got}, {1'b1, 8'h00});
    apply(1'b1, 8'h00, got);
    check("R3 inv 00", {out_valid, got}, {1'b1, 8'h52});

    // exhaustive forward, back to back
    for (int v = 0; v < 256; v++) begin
      apply(1'b0, 8'(v), got);
      check("R1 forward", {out_valid, got}, {1'b1, ref_fwd(8'(v))});
    end
    // exhaustive inverse, descending order
    for (int v = 255; v >= 0; v--) begin
      apply(1'b1, 8'(v), got);
      check("R2 inverse", {out_valid, got}, {1'b1, ref_bwd(8'(v))});
    end

    // idle edges: valid drops, output held while inputs wander
    held = out_byte;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_inv   = k[0];
      in_byte  = 8'(8'h3c + 8'(k) * 8'h51);
      @(posedge clk);
      #1;
      check("R4 valid low", {8'h00, out_valid}, 9'h000);
      check("R5 hold", {1'b0, out_byte}, {1'b0, held});
    end

    // alternating direction, back to back
    for (int v = 0; v < 64; v++) begin
      logic [7:0] b = 8'(v * 7 + 3);
      logic dir = v[0];
      apply(dir, b, got);
      check("R8 alternate", {1'b0, got}, {1'b0, dir ? ref_bwd(b) : ref_fwd(b)});
    end

    // round trip through the block for every byte
    for (int v = 0; v < 256; v++) begin
      apply(1'b0, 8'(v), fwd);
      apply(1'b1, fwd, got);
      check("R7 roundtrip", {1'b0, got}, {1'b0, 8'(v)});
    end

    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R4 final drop", {8'h00, out_valid}, 9'h000);
    finish_run();
  end

endmodule